// File: doc/BRIEF.md
# Security-Aware Interrupt Priority Store

This block holds one 8-bit priority value per interrupt and serves register reads and writes into that store. Each request names a byte offset into the priority window, an access width (byte, halfword or word) and whether the caller is secure. The priority of interrupt `n` lives at byte offset `n`. A word access covers four neighbouring interrupts. Interrupts below 32 and at or above the implemented count have no storage.

Two inputs decide what a caller may see. One is the per-interrupt group vector. The other is a global security-disable flag. When security is enabled, a non-secure caller cannot touch interrupts of group 0. For group-1 interrupts, that caller works through a translated view that confines its values to the lower-priority half of the range. Secure callers always use raw values, and so does every caller while security is disabled.

Read data returns two cycles after the request. Each accepted write produces a one-cycle update pulse that carries the interrupt number, so priority-selection logic outside this block can re-evaluate.

Top module: `irq_prio_regs`

## Requirements
- R1: After reset every priority field reads 0 through a secure access.
- R2: A byte access (req_size 0) addresses interrupt `req_offset`. A read returns that priority in bits 7:0 with bits 31:8 zero. A write changes only that one field.
- R3: A word access (req_size 2) ignores offset bits 1:0 and covers interrupts base to base+3, where base is the offset with bits 1:0 cleared. Interrupt base+k sits in bits 8k+7:8k.
- R4: A secure access, or any access while sec_disable is 1, reads and writes the stored value unchanged.
- R5: A non-secure access while sec_disable is 0 to an interrupt whose group_bits entry is 0 reads 0 in that field and leaves the field unchanged on a write.
- R6: A non-secure read while sec_disable is 0 of a group-1 interrupt returns the stored value shifted left by one, truncated to 8 bits.
- R7: A non-secure write while sec_disable is 0 to a group-1 interrupt stores 0x80 ORed with the written value shifted right by one.
- R8: Interrupts below 32, or at or above NUM_IRQ, read 0, and byte writes to them are ignored.
- R9: A word write is ignored in every lane unless base is at least 32 and base+3 is below NUM_IRQ.
- R10: Halfword accesses (req_size 1) and req_size 3 read 0, change nothing and produce no update pulse.
- R11: A read request accepted at a clock edge raises rsp_valid, with its data, for the one cycle that follows the next edge. Writes produce no rsp_valid.
- R12: A write that passes the range checks raises upd_valid for one cycle after its edge. upd_irq then equals the byte offset for a byte write, or base for a word write. This happens even when group masking suppresses some lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_secure | input | 1 | Caller is secure |
| req_offset | input | ADDR_W | Byte offset into the priority window |
| req_wdata | input | 32 | Write data |
| group_bits | input | NUM_IRQ | Group of each interrupt, 1 = group 1 |
| sec_disable | input | 1 | Single security state, no translation or masking |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| upd_valid | output | 1 | Accepted-write pulse |
| upd_irq | output | ADDR_W | Interrupt number of the accepted write |

## Verification
The assertions check the following on every cycle:
- read latency;
- halfword reads return zero and raise no update pulse;
- non-secure read data always has bit 0 of each lane clear;
- non-secure writes always reach storage with bit 7 set;
- update pulses only name interrupts that have storage.

The bench's scenarios are needed for the rest. These are:
- the actual stored values and the lane placement;
- group masking against a changing group vector;
- the all-or-nothing rule for a word write that runs past the last interrupt, which the bench exercises with an interrupt count that is not a multiple of four;
- the state left after reset.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int PRIO_W       = 8;
  localparam int LANES        = 4;
  localparam int FIRST_SHARED = 32;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_RSVD = 2'd3
  } acc_size_e;

  // non-secure write: forced into the lower-priority half
  function automatic logic [PRIO_W-1:0] ns_store(input logic [PRIO_W-1:0] v);
    return {1'b1, v[PRIO_W-1:1]};
  endfunction

  // non-secure read view of a stored priority
  function automatic logic [PRIO_W-1:0] ns_view(input logic [PRIO_W-1:0] p);
    return {p[PRIO_W-2:0], 1'b0};
  endfunction

endpackage

// File: rtl/irq_prio_bank.sv
module irq_prio_bank import irq_prio_pkg::*; #(
  parameter int ROWS  = 16,
  parameter int ROW_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ROW_W-1:0]  addr,
  input  logic [PRIO_W-1:0] wdata,
  output logic [PRIO_W-1:0] rdata
);

  logic [PRIO_W-1:0] mem [ROWS];
  logic [ROWS-1:0]   written;
  logic [PRIO_W-1:0] q;
  logic              q_written;

  // storage array without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end

  // per-row written flags stand in for a zeroed memory after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      written   <= '0;
      q_written <= 1'b0;
    end else begin
      if (we) written[addr] <= 1'b1;
      if (re) q_written <= written[addr];
    end
  end

  assign rdata = q_written ? q : '0;

endmodule

// File: rtl/irq_prio_lane_ctl.sv
module irq_prio_lane_ctl import irq_prio_pkg::*; #(
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W  = 10,
  parameter int LANE    = 0
) (
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               is_byte,
  input  logic               is_word,
  input  logic               ns_restrict,
  input  logic               wr_accept,
  input  logic [ADDR_W-1:0]  req_offset,
  input  logic [31:0]        req_wdata,
  input  logic [NUM_IRQ-1:0] group_bits,
  output logic               lane_we,
  output logic               lane_re,
  output logic [PRIO_W-1:0]  lane_wdata
);

  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam logic [1:0]      LSEL     = 2'(LANE);
  localparam logic [ADDR_W:0] FIRST_ID = (ADDR_W+1)'(FIRST_SHARED);
  localparam logic [ADDR_W:0] LIMIT_ID = (ADDR_W+1)'(NUM_IRQ);

  logic [ADDR_W-1:0] irq;
  logic [IDX_W-1:0]  gidx;
  logic              in_range, grp, sel, perm;
  logic [PRIO_W-1:0] raw;

  always_comb begin
    irq      = {req_offset[ADDR_W-1:2], LSEL};
    gidx     = irq[IDX_W-1:0];
    in_range = ({1'b0, irq} >= FIRST_ID) && ({1'b0, irq} < LIMIT_ID);
    grp      = in_range ? group_bits[gidx] : 1'b0;
    sel      = is_word || (is_byte && (req_offset[1:0] == LSEL));
    perm     = !ns_restrict || grp;
    raw      = is_word ? req_wdata[8*LANE +: 8] : req_wdata[7:0];
  end

  assign lane_re    = req_valid && !req_write && sel && in_range && perm;
  assign lane_we    = req_valid && req_write && wr_accept && sel && in_range && perm;
  assign lane_wdata = ns_restrict ? ns_store(raw) : raw;

endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs import irq_prio_pkg::*; #(
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W  = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [1:0]         req_size,
  input  logic               req_secure,
  input  logic [ADDR_W-1:0]  req_offset,
  input  logic [31:0]        req_wdata,
  input  logic [NUM_IRQ-1:0] group_bits,
  input  logic               sec_disable,
  output logic               rsp_valid,
  output logic [31:0]        rsp_data,
  output logic               upd_valid,
  output logic [ADDR_W-1:0]  upd_irq
);

  localparam int ROWS  = (NUM_IRQ + LANES - 1) / LANES;
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [ADDR_W:0] FIRST_ID = (ADDR_W+1)'(FIRST_SHARED);
  localparam logic [ADDR_W:0] LIMIT_ID = (ADDR_W+1)'(NUM_IRQ);

  acc_size_e         sz;
  logic              is_byte, is_word, ns_restrict;
  logic              byte_ok, word_ok, wr_accept;
  logic [ADDR_W-1:0] base;
  logic [ROW_W-1:0]  row;

  always_comb begin
    sz          = acc_size_e'(req_size);
    is_byte     = (sz == ACC_BYTE);
    is_word     = (sz == ACC_WORD);
    ns_restrict = !req_secure && !sec_disable;
    base        = {req_offset[ADDR_W-1:2], 2'b00};
    byte_ok     = ({1'b0, req_offset} >= FIRST_ID) && ({1'b0, req_offset} < LIMIT_ID);
    word_ok     = ({1'b0, base} >= FIRST_ID) &&
                  (({1'b0, base} + (ADDR_W+1)'(3)) < LIMIT_ID);
    wr_accept   = is_byte ? byte_ok : (is_word ? word_ok : 1'b0);
    row         = req_offset[ROW_W+1:2];
  end

  logic [LANES-1:0] lane_we, lane_re;
  logic [PRIO_W-1:0] lane_wd [LANES];
  logic [PRIO_W-1:0] lane_q  [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    irq_prio_lane_ctl #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .LANE(l)) u_ctl (
      .req_valid  (req_valid),
      .req_write  (req_write),
      .is_byte    (is_byte),
      .is_word    (is_word),
      .ns_restrict(ns_restrict),
      .wr_accept  (wr_accept),
      .req_offset (req_offset),
      .req_wdata  (req_wdata),
      .group_bits (group_bits),
      .lane_we    (lane_we[l]),
      .lane_re    (lane_re[l]),
      .lane_wdata (lane_wd[l])
    );

    irq_prio_bank #(.ROWS(ROWS), .ROW_W(ROW_W)) u_bank (
      .clk  (clk),
      .rst  (rst),
      .we   (lane_we[l]),
      .re   (lane_re[l]),
      .addr (row),
      .wdata(lane_wd[l]),
      .rdata(lane_q[l])
    );

    // R7: every non-secure store lands in the lower-priority half
    assert_ns_store_high_R7: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_write && !req_secure && !sec_disable && lane_we[l])
        |-> lane_wd[l][PRIO_W-1]);
  end

  // stage 1: control travelling alongside the bank read
  logic             s1_rd, s1_ns, s1_byte;
  logic [1:0]       s1_lane;
  logic [LANES-1:0] s1_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_rd   <= 1'b0;
      s1_ok   <= '0;
      s1_ns   <= 1'b0;
      s1_byte <= 1'b0;
      s1_lane <= '0;
    end else begin
      s1_rd   <= req_valid && !req_write;
      s1_ok   <= lane_re;
      s1_ns   <= ns_restrict;
      s1_byte <= is_byte;
      s1_lane <= req_offset[1:0];
    end
  end

  // stage 2: view translation and lane packing
  logic [PRIO_W-1:0] view [LANES];
  logic [31:0]       rd_next;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      view[l] = s1_ok[l] ? (s1_ns ? ns_view(lane_q[l]) : lane_q[l]) : '0;
    end
    rd_next = s1_byte ? {24'h0, view[s1_lane]} : {view[3], view[2], view[1], view[0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      upd_valid <= 1'b0;
      upd_irq   <= '0;
    end else begin
      rsp_valid <= s1_rd;
      rsp_data  <= s1_rd ? rd_next : '0;
      upd_valid <= req_valid && req_write && wr_accept;
      upd_irq   <= is_word ? base : req_offset;
    end
  end

  assert_rd_latency_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> ##1 rsp_valid);

  assert_half_rd_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_size == ACC_HALF) |=> ##1 (rsp_data == 32'h0));

  assert_half_no_upd_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_size == ACC_HALF) |=> !upd_valid);

  assert_ns_view_even_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !req_secure && !sec_disable)
      |=> ##1 ((rsp_data & 32'h01010101) == 32'h0));

  assert_upd_range_R12: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> (({1'b0, upd_irq} >= FIRST_ID) && ({1'b0, upd_irq} < LIMIT_ID)));

  assert_upd_cause_R12: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> $past(req_valid && req_write));

endmodule

// File: tb/sim_irq_prio_regs.sv
module sim_irq_prio_regs;

  localparam int N  = 62;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [1:0]    req_size = 2'd0;
  logic          req_secure = 1'b1;
  logic [AW-1:0] req_offset = '0;
  logic [31:0]   req_wdata = '0;
  logic [N-1:0]  grp = '0;
  logic          ds = 1'b0;
  logic          rsp_valid, upd_valid;
  logic [31:0]   rsp_data;
  logic [AW-1:0] upd_irq;

  always #2 clk = ~clk;

  irq_prio_regs #(.NUM_IRQ(N), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_secure(req_secure), .req_offset(req_offset),
    .req_wdata(req_wdata), .group_bits(grp), .sec_disable(ds),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .upd_valid(upd_valid), .upd_irq(upd_irq)
  );

  int   total = 0;
  int   fails = 0;
  bit   done  = 1'b0;
  logic [7:0] model [N];

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_lane(input int irq, input bit sec);
    if (irq < 32 || irq >= N) return 8'h00;
    if (!sec && !ds) begin
      if (!grp[irq]) return 8'h00;
      return {model[irq][6:0], 1'b0};
    end
    return model[irq];
  endfunction

  function automatic logic [31:0] exp_read(input logic [1:0] sz, input int off, input bit sec);
    int b = off & ~3;
    if (sz == 2'd0) return {24'h0, exp_lane(off, sec)};
    if (sz == 2'd2) return {exp_lane(b+3, sec), exp_lane(b+2, sec),
                            exp_lane(b+1, sec), exp_lane(b, sec)};
    return 32'h0;
  endfunction

  task automatic apply_lane(input int irq, input bit sec, input logic [7:0] v);
    if (irq < 32 || irq >= N) return;
    if (!sec && !ds) begin
      if (!grp[irq]) return;
      model[irq] = 8'h80 | (v >> 1);
    end else begin
      model[irq] = v;
    end
  endtask

  task automatic run_op(input bit wr, input logic [1:0] sz, input int off, input bit sec,
                        input logic [31:0] wd, input string req);
    logic [31:0] exp;
    bit          exp_upd;
    int          exp_irq;
    int          b = off & ~3;
    exp     = exp_read(sz, off, sec);
    exp_upd = 1'b0;
    exp_irq = 0;
    if (sz == 2'd0 && off >= 32 && off < N) begin exp_upd = 1'b1; exp_irq = off; end
    if (sz == 2'd2 && b >= 32 && b + 3 < N)  begin exp_upd = 1'b1; exp_irq = b;   end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_secure = sec;
    req_offset = AW'(off); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) begin
      check(upd_valid == exp_upd, "R12 upd_valid", 32'(upd_valid), 32'(exp_upd));
      if (exp_upd)
        check(upd_irq == AW'(exp_irq), "R12 upd_irq", 32'(upd_irq), 32'(exp_irq));
      check(rsp_valid == 1'b0, "R11 no rsp on write", 32'(rsp_valid), 32'h0);
      if (exp_upd) begin
        if (sz == 2'd0) apply_lane(off, sec, wd[7:0]);
        else for (int k = 0; k < 4; k++) apply_lane(b + k, sec, wd[8*k +: 8]);
      end
    end else begin
      check(rsp_valid == 1'b0, "R11 early rsp", 32'(rsp_valid), 32'h0);
      @(negedge clk);
      check(rsp_valid == 1'b1, "R11 rsp_valid", 32'(rsp_valid), 32'h1);
      check(rsp_data == exp, req, rsp_data, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < N; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1: reset state, R8 range ends included
    check(rsp_valid == 1'b0 && upd_valid == 1'b0, "R1 outputs idle", 32'(rsp_valid), 32'h0);
    for (int o = 0; o < N + 4; o += 4) run_op(1'b0, 2'd2, o, 1'b1, 32'h0, "R1 reset read");

    // R2/R4: secure byte write, raw value
    run_op(1'b1, 2'd0, 37, 1'b1, 32'hFFFF_FF5A, "R2");
    run_op(1'b0, 2'd0, 37, 1'b1, 32'h0, "R2 byte read");
    run_op(1'b0, 2'd2, 36, 1'b1, 32'h0, "R2 single lane written");

    // R3: word access with unaligned offset, lane order
    run_op(1'b1, 2'd2, 42, 1'b1, 32'h44332211, "R3");
    run_op(1'b0, 2'd2, 41, 1'b1, 32'h0, "R3 word lanes");
    run_op(1'b0, 2'd0, 43, 1'b1, 32'h0, "R3 top lane byte");

    // R5: non-secure, group 0 hidden and protected
    grp = '0; ds = 1'b0;
    run_op(1'b0, 2'd2, 40, 1'b0, 32'h0, "R5 ns read group0");
    run_op(1'b1, 2'd2, 40, 1'b0, 32'hA5A5A5A5, "R5 ns write group0");
    run_op(1'b0, 2'd2, 40, 1'b1, 32'h0, "R5 value kept");

    // R6/R7: non-secure translated view of group-1
    grp[41] = 1'b1; grp[42] = 1'b1;
    run_op(1'b0, 2'd2, 40, 1'b0, 32'h0, "R6 ns view");
    run_op(1'b1, 2'd0, 42, 1'b0, 32'h0000_0010, "R7");
    run_op(1'b0, 2'd0, 42, 1'b1, 32'h0, "R7 stored 0x88");
    run_op(1'b0, 2'd0, 42, 1'b0, 32'h0, "R6 ns readback");

    // R4: security disabled, non-secure uses raw values
    ds = 1'b1;
    run_op(1'b1, 2'd0, 40, 1'b0, 32'h0000_0003, "R4");
    run_op(1'b0, 2'd0, 40, 1'b0, 32'h0, "R4 raw read ds");
    ds = 1'b0;

    // R8: out of range
    run_op(1'b1, 2'd0, 31, 1'b1, 32'h77, "R8 below 32");
    run_op(1'b0, 2'd0, 31, 1'b1, 32'h0, "R8 read below 32");
    run_op(1'b1, 2'd0, N, 1'b1, 32'h77, "R8 at limit");
    run_op(1'b0, 2'd0, N + 1, 1'b1, 32'h0, "R8 read above limit");

    // R9: word write crossing limit is fully ignored
    run_op(1'b1, 2'd2, 60, 1'b1, 32'hDDCCBBAA, "R9");
    run_op(1'b0, 2'd2, 60, 1'b1, 32'h0, "R9 nothing written");
    run_op(1'b1, 2'd2, 28, 1'b1, 32'hDDCCBBAA, "R9 base below 32");

    // R10: halfword and reserved sizes
    run_op(1'b1, 2'd1, 44, 1'b1, 32'h12345678, "R10");
    run_op(1'b1, 2'd3, 48, 1'b1, 32'h12345678, "R10 rsvd write");
    run_op(1'b0, 2'd1, 42, 1'b1, 32'h0, "R10 half read");
    run_op(1'b0, 2'd2, 44, 1'b1, 32'h0, "R10 unchanged");

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int          pick = $urandom_range(0, 19);
      logic [1:0]  sz   = (pick < 8) ? 2'd0 : (pick < 18) ? 2'd2 : 2'(pick - 17);
      int          off  = $urandom_range(24, N + 5);
      bit          sec  = $urandom_range(0, 1);
      bit          wr   = $urandom_range(0, 1);
      if (n % 40 == 0) begin
        logic [63:0] t = {$urandom(), $urandom()};
        grp = t[N-1:0];
        ds  = ($urandom_range(0, 3) == 0);
      end
      run_op(wr, sz, off, sec, $urandom(),
             sz == 2'd0 ? "R2 random" : sz == 2'd2 ? "R3 random" : "R10 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule